// File: doc/BRIEF.md
# Set-Associative Tag Controller with Pinned-Way Replacement

This block holds the tags and valid bits of a set-associative data cache and answers lookups. Each accepted request is split into byte offset, set index and tag. After a fixed two-cycle latency it returns a one-cycle response that says whether the line is present and in which way. On a miss the response names the victim way chosen for the new line. A stall output stays high until the fill logic signals that the line has arrived. At that point the new tag is written into the victim way and marked valid.

System software can pin ways through a mask input. A pinned way still takes part in hit detection, but it is never offered as a victim.
- If the set has an empty way that is not pinned, the lowest-numbered such way is used.
- Otherwise the victim comes from a free-running 16-bit LFSR. If the LFSR picks a pinned way, the search steps forward to the next unpinned way.
- A miss while every way is pinned is reported as an error, and nothing is allocated.

The default configuration is 16 ways, 16 sets and 128-byte lines. A smaller two-way, 64-byte-line variant is obtained through the parameters alone.

Top module: `rsv_way_cache_ctrl`

## Requirements
- R1: After reset no line is valid, `req_ready` is 1, and `stall` and `rsp_valid` are 0, so the first access to any address misses.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is then low in the following cycle and high for exactly one cycle in the cycle after that. `req_ready` is 0 while a request is in flight.
- R3: When a valid way of the indexed set holds the request tag, the response has `rsp_hit`=1 and `rsp_way` equal to that way's index. This holds whether or not the way is pinned.
- R4: On a miss that can allocate, the response has `rsp_hit`=0 and `rsp_err`=0, and `stall` rises in the response cycle. `stall` stays high until `fill_done` is sampled high, and in the cycle after that `stall` is 0 and `req_ready` is 1.
- R5: The fill writes the request tag into way `rsp_way` of the indexed set. A later access to the same line hits that way.
- R6: Bit i of `pin_mask` pins way i. A miss response never reports a pinned way as victim, so pinned lines stay resident across any number of misses.
- R7: If the set has invalid ways that are not pinned, the victim is the lowest-indexed of them.
- R8: When every unpinned way of a set is valid, the victim is pseudo-random. Over a long run of misses to one set, every unpinned way gets chosen.
- R9: A miss while every bit of `pin_mask` is 1 responds with `rsp_hit`=0 and `rsp_err`=1 and raises no stall. It allocates nothing, so the same access misses again. Hits still work in this state.
- R10: Address bits below log2(LINE_BYTES) are the byte offset and do not affect lookup. The next log2(SETS) bits select the set, and the remaining upper bits form the tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_mask | input | WAYS | Ways excluded from eviction (bit i = way i) |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Line found |
| rsp_err | output | 1 | Miss with no allocatable way |
| rsp_way | output | log2(WAYS) | Hit way, or victim way on a miss |
| stall | output | 1 | Miss outstanding, waiting for fill |
| fill_done | input | 1 | Line fill complete; commit tag |

## Verification
The bench first fills one set completely with the pin mask clear. It then pins the top four ways and drives two hundred conflicting misses into that set.
- A controller that evicts pinned ways would lose those lines, and later re-accesses would miss.
- A controller whose walk skips a region would leave some unpinned way never chosen.

Empty-way preference is checked on fresh sets. A design that ignored it would place lines in random ways instead of the lowest free one.

The all-pinned case checks that there is no stall and no allocation. A design that allocated anyway would hit on the retry.

Offset-only address changes must hit the same way. Random traffic with a changing mask is compared against a bench tag model.

// File: rtl/rwc_pkg.sv
// Shared types for the reserved-way tag controller.
// Assumes nothing beyond a synchronous clock domain.
package rwc_pkg;
    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/rwc_lfsr.sv
// Free-running 16-bit maximal-length LFSR (x^16+x^14+x^13+x^11+1).
// Advances every cycle; exposes only the low OUT_W bits as a way pick.
// Assumes SEED is non-zero.
module rwc_lfsr #(
    parameter int          OUT_W = 4,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] pick
);
    logic [15:0] state_q;
    logic        fb;

    // feedback tap combination
    assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];

    // shift register, loads seed in reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= {state_q[14:0], fb};
    end

    assign pick = state_q[OUT_W-1:0];
endmodule

// File: rtl/rwc_tag_store.sv
// Tag and valid register arrays with parallel compare on one read set.
// One write port commits a tag and sets the valid bit.
// Assumes at most one valid way per set can match a given tag.
module rwc_tag_store #(
    parameter int WAYS  = 16,
    parameter int SETS  = 16,
    parameter int TAG_W = 21,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAYS-1:0]  row_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [TAG_W-1:0] tags_q [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  match;

    // valid bits: cleared by reset, set by fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx][wr_way] <= 1'b1;
        end
    end

    // tag words: written on fill, no reset needed
    always_ff @(posedge clk) begin
        if (wr_en) tags_q[wr_idx][wr_way] <= wr_tag;
    end

    // per-way comparators
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[rd_idx][w] && (tags_q[rd_idx][w] == rd_tag);
    end

    assign row_valid = valid_q[rd_idx];
    assign hit       = |match;

    // encode the matching way index
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = w[WAY_W-1:0];
        end
    end
endmodule

// File: rtl/rwc_victim_sel.sv
// Victim choice for one set: lowest invalid unpinned way first, otherwise
// a forward walk from the random start to the first unpinned way.
// Assumes WAYS is a power of two so the walk wraps by truncation.
module rwc_victim_sel #(
    parameter int WAYS = 16,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  row_valid,
    input  logic [WAYS-1:0]  pin_mask,
    input  logic [WAY_W-1:0] start,
    output logic [WAY_W-1:0] victim,
    output logic             found
);
    logic [WAYS-1:0]  empty_free;
    logic [WAY_W-1:0] empty_way, walk_way, cand;
    logic             have_empty, have_walk;

    // lowest-index empty way that may be replaced
    always_comb begin
        empty_free = ~row_valid & ~pin_mask;
        empty_way  = '0;
        have_empty = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (empty_free[i] && !have_empty) begin
                empty_way  = i[WAY_W-1:0];
                have_empty = 1'b1;
            end
        end
    end

    // walk forward from the random start to an unpinned way
    always_comb begin
        walk_way  = '0;
        have_walk = 1'b0;
        cand      = '0;
        for (int k = 0; k < WAYS; k++) begin
            cand = start + k[WAY_W-1:0];
            if (!pin_mask[cand] && !have_walk) begin
                walk_way  = cand;
                have_walk = 1'b1;
            end
        end
    end

    // final choice
    assign victim = have_empty ? empty_way : walk_way;
    assign found  = have_walk;
endmodule

// File: rtl/rsv_way_cache_ctrl.sv
// Tag, lookup and replacement controller for a set-associative cache with
// software-pinned ways. Fixed two-cycle response; stall on miss until fill.
// Assumes WAYS and SETS are powers of two and pin_mask is stable during a
// lookup. Data storage and fill datapath live elsewhere.
module rsv_way_cache_ctrl #(
    parameter int          ADDR_W     = 32,
    parameter int          WAYS       = 16,
    parameter int          SETS       = 16,
    parameter int          LINE_BYTES = 128,
    parameter logic [15:0] LFSR_SEED  = 16'hACE1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAYS-1:0]   pin_mask,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              stall,
    input  logic              fill_done
);
    import rwc_pkg::*;

    ctl_state_t              state_q;
    logic [ADDR_W-OFF_W-1:0] line_q;
    logic [IDX_W-1:0]        idx;
    logic [TAG_W-1:0]        tag;
    logic                    lk_hit, vic_found;
    logic [WAY_W-1:0]        lk_way, vic_way, rnd_start;
    logic [WAYS-1:0]         row_valid;
    logic                    commit;

    // split the captured line address
    assign idx    = line_q[IDX_W-1:0];
    assign tag    = line_q[ADDR_W-OFF_W-1 -: TAG_W];
    assign commit = (state_q == ST_FILL) && fill_done;

    rwc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(idx), .rd_tag(tag),
        .hit(lk_hit), .hit_way(lk_way), .row_valid(row_valid),
        .wr_en(commit), .wr_idx(idx), .wr_way(rsp_way), .wr_tag(tag)
    );

    rwc_lfsr #(.OUT_W(WAY_W), .SEED(LFSR_SEED)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .pick(rnd_start)
    );

    rwc_victim_sel #(.WAYS(WAYS)) i_vsel (
        .row_valid(row_valid), .pin_mask(pin_mask), .start(rnd_start),
        .victim(vic_way), .found(vic_found)
    );

    // request capture, lookup result and fill sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            line_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_way   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    line_q  <= req_addr[ADDR_W-1:OFF_W];
                    state_q <= ST_LOOK;
                end
                ST_LOOK: begin
                    rsp_valid <= 1'b1;
                    if (lk_hit) begin
                        rsp_hit <= 1'b1; rsp_err <= 1'b0;
                        rsp_way <= lk_way; state_q <= ST_IDLE;
                    end else if (!vic_found) begin
                        rsp_hit <= 1'b0; rsp_err <= 1'b1;
                        rsp_way <= '0;    state_q <= ST_IDLE;
                    end else begin
                        rsp_hit <= 1'b0; rsp_err <= 1'b0;
                        rsp_way <= vic_way; state_q <= ST_FILL;
                    end
                end
                ST_FILL: if (fill_done) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign stall     = (state_q == ST_FILL);
endmodule

// File: rtl/rwc_checker.sv
// Protocol and replacement-safety properties, bound to the top module.
module rwc_checker #(
    parameter int WAYS = 16,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WAYS-1:0]  pin_mask,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_err,
    input logic [WAY_W-1:0] rsp_way,
    input logic             stall,
    input logic             fill_done
);
    localparam logic [WAYS-1:0] ONE = 1;

    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);
    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R4
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !rsp_err) |-> stall);
    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !fill_done) |=> stall);
    // R4
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && fill_done) |=> (!stall && req_ready));
    // R4
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !req_ready);
    // R6
    no_pinned_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !rsp_err) |-> (($past(pin_mask) & (ONE << rsp_way)) == '0));
    // R9
    err_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (!rsp_hit && !stall));
endmodule

bind rsv_way_cache_ctrl rwc_checker #(.WAYS(WAYS)) i_rwc_checker (
    .clk(clk), .rst_n(rst_n), .pin_mask(pin_mask),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_way(rsp_way), .stall(stall), .fill_done(fill_done)
);

// File: tb/test_rsv_way_cache_ctrl.sv
module test_rsv_way_cache_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32, WAYS = 16, SETS = 16, LINE_BYTES = 128;
    localparam int WAY_W = 4, OFF_W = 7, IDX_W = 4, TAG_W = 21;

    logic clk = 0, rst_n = 0;
    logic [WAYS-1:0] pin_mask = '0;
    logic req_valid = 0, fill_done = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, rsp_valid, rsp_hit, rsp_err, stall;
    logic [WAY_W-1:0] rsp_way;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [TAG_W-1:0] mtag [SETS][WAYS];
    bit               mval [SETS][WAYS];
    bit               seen [WAYS];

    always #(CLK_PERIOD/2) clk = ~clk;

    rsv_way_cache_ctrl #(.ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS),
                         .LINE_BYTES(LINE_BYTES)) i_rsv_way_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_mask(pin_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
        .rsp_way(rsp_way), .stall(stall), .fill_done(fill_done));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model_hit(input logic [TAG_W-1:0] t, input int s);
        for (int w = 0; w < WAYS; w++) if (mval[s][w] && mtag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic int lowest_free(input int s);
        for (int w = 0; w < WAYS; w++) if (!mval[s][w] && !pin_mask[w]) return w;
        return -1;
    endfunction

    // one complete request; returns the reported way
    task automatic access(input logic [TAG_W-1:0] t, input int s,
                          input logic [OFF_W-1:0] off, input int fw, output int way);
        int exp_w, lf;
        exp_w = model_hit(t, s);
        lf    = lowest_free(s);
        @(negedge clk);
        chk(req_ready == 1, "R2", "ready when idle", req_ready, 1);
        req_valid = 1; req_addr = {t, s[IDX_W-1:0], off};
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 0 && req_ready == 0, "R2", "gap cycle", {rsp_valid, req_ready}, 0);
        @(negedge clk);
        chk(rsp_valid == 1, "R2", "response strobe", rsp_valid, 1);
        way = int'(rsp_way);
        if (exp_w >= 0) begin
            chk(rsp_hit == 1 && rsp_err == 0, "R3", "hit flag", rsp_hit, 1);
            chk(way == exp_w, "R3", "hit way", way, exp_w);
            chk(stall == 0, "R3", "no stall on hit", stall, 0);
            @(negedge clk);
            chk(rsp_valid == 0, "R2", "strobe one cycle", rsp_valid, 0);
        end else if (&pin_mask) begin
            chk(rsp_hit == 0 && rsp_err == 1, "R9", "error flag", rsp_err, 1);
            chk(stall == 0, "R9", "no stall", stall, 0);
        end else begin
            chk(rsp_hit == 0 && rsp_err == 0, "R4", "miss flags", {rsp_hit, rsp_err}, 0);
            chk(stall == 1, "R4", "stall on miss", stall, 1);
            chk(pin_mask[way] == 0, "R6", "victim unpinned", way, -1);
            if (lf >= 0) chk(way == lf, "R7", "lowest empty way", way, lf);
            else seen[way] = 1;
            for (int i = 0; i < fw; i++) begin
                @(negedge clk);
                chk(stall == 1, "R4", "stall held", stall, 1);
            end
            fill_done = 1;
            @(negedge clk);
            fill_done = 0;
            chk(stall == 0 && req_ready == 1, "R4", "release", {stall, req_ready}, 1);
            mtag[s][way] = t; mval[s][way] = 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int w;
        void'($urandom(32'h5EED));
        for (int s = 0; s < SETS; s++) for (int k = 0; k < WAYS; k++) mval[s][k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1 && stall == 0 && rsp_valid == 0, "R1", "reset outputs",
            {req_ready, stall, rsp_valid}, 4);
        access(21'h1, 0, 0, 0, w);
        chk(w == 0, "R1", "first access allocates way 0", w, 0);
        // R5 refill hits the allocated way
        access(21'h1, 0, 7'h11, 0, w);
        // R7/R5: fill set 5 completely with no pins
        for (int k = 0; k < WAYS; k++) access(21'h200 + 21'(k), 5, 0, k % 3, w);
        for (int k = 0; k < WAYS; k++) begin
            access(21'h200 + 21'(k), 5, 7'(k), 0, w);
            chk(w == k, "R5", "fill placed tag", w, k);
        end
        // R6/R8: pin ways 12..15 and drive many misses into set 5
        pin_mask = 16'hF000;
        for (int k = 0; k < WAYS; k++) seen[k] = 0;
        for (int k = 12; k < WAYS; k++) access(21'h200 + 21'(k), 5, 0, 0, w);  // R3 pinned hit
        for (int n = 0; n < 200; n++) access(21'h1000 + 21'(n), 5, 0, $urandom_range(0, 3), w);
        for (int k = 0; k < 12; k++) chk(seen[k] == 1, "R8", "unpinned way chosen", k, 1);
        for (int k = 12; k < WAYS; k++) begin
            access(21'h200 + 21'(k), 5, 7'h7F, 0, w);
            chk(w == k, "R6", "pinned line survived", w, k);
        end
        // R10 offset bits ignored, neighbouring set distinct
        access(21'h33, 9, 7'h00, 0, w);
        access(21'h33, 9, 7'h7F, 0, w);
        access(21'h33, 10, 7'h05, 0, w);
        // R9 all pinned
        pin_mask = '1;
        access(21'h77, 11, 0, 0, w);
        access(21'h77, 11, 0, 0, w);
        access(21'h33, 9, 7'h40, 0, w);
        // random traffic against the model
        for (int n = 0; n < 400; n++) begin
            if (n % 25 == 0) begin
                pin_mask = 16'($urandom);
                if (&pin_mask) pin_mask[0] = 0;
            end
            access(21'h100 + 21'($urandom_range(0, 23)), $urandom_range(0, 3),
                   7'($urandom), $urandom_range(0, 2), w);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule